// File: doc/BRIEF.md
# Touch Panel Driver and Power-State Controller

This block sits beside the conversion sequencer of a resistive touch-screen ADC. Each time a control byte is latched, it records the channel address, the reference-mode bit and the two power bits. It then combines them with the sequencer's acquire and convert phases to drive the panel switch enables, the temperature-diode bias, the battery divider, the internal reference enable and the ADC power enable.

Between measurements the block arms the pen-detect path. The Y-minus plate is grounded, the pull-up is connected to X-plus, and the pen output follows the digital touch sense. During a measurement the pen output is forced to a fixed level, and the sense is ignored. Every output comes from a register, so a switch enable cannot glitch when the phase changes.

The sequencer supplies single-cycle pulses. `cfg_load` marks a latched byte, `busy_rise` marks the rising edge of the busy indication, and `conv_end` marks the clock edge at which the last result bit has been shifted out.

Top module: `touch_pwr_ctl`

## Requirements
- R1: The diode bias is on only in the cycle after a sampled acquire phase, and only for address 3'b000 (low current) or 3'b111. For 3'b111 the high-current select is also on. The bias is off during conversion.
- R2: For address 3'b010 the battery divider is on in the cycle after a sampled acquire phase and off during conversion. It is never on for any other address.
- R3: With the reference-mode bit at 1 (single-ended), a position channel's drivers are on during acquisition only.
- R4: With the reference-mode bit at 0 (differential), a position channel's drivers stay on through acquisition and conversion. On the other channels (000, 010, 110, 111) this bit has no effect and no driver is ever on.
- R5: The driver selection is fixed by address:
  - 3'b001 turns on Y+ and Y-.
  - 3'b101 turns on X+ and X-.
  - 3'b011 and 3'b100 turn on Y+ and X-.
- R6: If bit 0 of the power field is 1, the ADC stays powered. If it is 0, the ADC is powered only from the byte load until the conversion end.
- R7: The reference enable takes bit 1 of the power field of the latest byte, and only when `busy_rise` pulses. Neither a byte load nor a conversion end changes it.
- R8: While a measurement is in progress, the pull-up is off and `pen_irq_n` is forced. It is 0 for position channels (001, 011, 100, 101) and 1 for all others, whatever the touch sense.
- R9: After a conversion ends on a byte with power bit 0 = 0, the block re-arms. The Y-minus driver and the pull-up turn on, and `pen_irq_n` follows `pen_touch_n`. After a byte with power bit 0 = 1 the block stays disarmed: `pen_irq_n` = 1, with no pull-up and no Y-minus driver, until a byte with power bit 0 = 0 completes.
- R10: After reset the reference is off, the ADC is powered, every driver is off, the pull-up is off and `pen_irq_n` is 1.
- R11: A byte load in the same cycle as a conversion end starts the next measurement. The pen path is not re-armed, and the pen output stays forced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_load | input | 1 | Pulse: control byte latched |
| cfg_addr | input | 3 | Channel address of the byte |
| cfg_sgl | input | 1 | Reference mode: 1 single-ended, 0 differential |
| cfg_pd | input | 2 | Power field: bit 1 reference, bit 0 ADC stay-on |
| ph_acq | input | 1 | Acquire phase from the sequencer |
| ph_conv | input | 1 | Convert phase from the sequencer |
| busy_rise | input | 1 | Pulse: busy indication rises |
| conv_end | input | 1 | Pulse: last result bit shifted out |
| pen_touch_n | input | 1 | Digital touch sense, 0 = touched |
| drv_xp | output | 1 | X+ driver enable |
| drv_xn | output | 1 | X- driver enable |
| drv_yp | output | 1 | Y+ driver enable |
| drv_yn | output | 1 | Y- driver enable |
| diode_bias_en | output | 1 | Temperature diode bias enable |
| diode_hi_bias | output | 1 | High-current diode bias select |
| bat_div_en | output | 1 | Battery divider enable |
| ref_en | output | 1 | Internal reference enable |
| adc_pwr_en | output | 1 | ADC power enable |
| xp_pullup_en | output | 1 | Pull-up to X+ connected |
| pen_irq_n | output | 1 | Pen interrupt level, active low |

## Verification
The bench sweeps all eight addresses in both reference modes. A design that ignored the mode bit would leave the drivers off during conversion in differential mode, or keep them on in single-ended mode. A swapped decode would light the wrong plate.

The bench separates a byte load from a busy pulse when checking the reference. A design that updated the reference at the byte boundary would change it one step early.

The re-arm cases cover a byte with power bit 0 = 1, a later byte with power bit 0 = 0, and a byte load in the same cycle as a conversion end. A design that re-armed on any conversion end would let the touch sense through or ground Y-minus in the middle of a measurement.

// File: rtl/tpc_pkg.sv
package tpc_pkg;
  localparam int CH_W = 3;

  localparam logic [CH_W-1:0] CH_TEMP_LO = 3'b000;
  localparam logic [CH_W-1:0] CH_YPOS    = 3'b001;
  localparam logic [CH_W-1:0] CH_BATT    = 3'b010;
  localparam logic [CH_W-1:0] CH_Z1      = 3'b011;
  localparam logic [CH_W-1:0] CH_Z2      = 3'b100;
  localparam logic [CH_W-1:0] CH_XPOS    = 3'b101;
  localparam logic [CH_W-1:0] CH_AUX     = 3'b110;
  localparam logic [CH_W-1:0] CH_TEMP_HI = 3'b111;

  typedef struct packed {
    logic xp;
    logic xn;
    logic yp;
    logic yn;
  } drv_t;

  function automatic logic is_touch_ch(input logic [CH_W-1:0] a);
    return (a == CH_YPOS) || (a == CH_Z1) || (a == CH_Z2) || (a == CH_XPOS);
  endfunction

  function automatic logic is_diode_ch(input logic [CH_W-1:0] a);
    return (a == CH_TEMP_LO) || (a == CH_TEMP_HI);
  endfunction

  function automatic drv_t touch_drivers(input logic [CH_W-1:0] a);
    drv_t d;
    d = '0;
    case (a)
      CH_YPOS: begin d.yp = 1'b1; d.yn = 1'b1; end
      CH_XPOS: begin d.xp = 1'b1; d.xn = 1'b1; end
      CH_Z1, CH_Z2: begin d.yp = 1'b1; d.xn = 1'b1; end
      default: d = '0;
    endcase
    return d;
  endfunction
endpackage

// File: rtl/tpc_state.sv
module tpc_state
  import tpc_pkg::*;
#(
  parameter logic RST_ADC_ON = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_load,
  input  logic [CH_W-1:0] cfg_addr,
  input  logic            cfg_sgl,
  input  logic [1:0]      cfg_pd,
  input  logic            busy_rise,
  input  logic            conv_end,
  output logic [CH_W-1:0] act_addr,
  output logic            act_sgl,
  output logic            act_pd0,
  output logic            in_meas,
  output logic            pen_armed,
  output logic            ref_en
);
  logic pend_ref;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_addr  <= CH_AUX;
      act_sgl   <= 1'b1;
      act_pd0   <= RST_ADC_ON;
      pend_ref  <= 1'b0;
      in_meas   <= 1'b0;
      pen_armed <= 1'b0;
      ref_en    <= 1'b0;
    end else begin
      if (cfg_load) begin
        act_addr  <= cfg_addr;
        act_sgl   <= cfg_sgl;
        act_pd0   <= cfg_pd[0];
        pend_ref  <= cfg_pd[1];
        in_meas   <= 1'b1;
        pen_armed <= 1'b0;
      end else if (conv_end && in_meas) begin
        in_meas   <= 1'b0;
        pen_armed <= ~act_pd0;
      end
      if (busy_rise) ref_en <= pend_ref;
    end
  end
endmodule

// File: rtl/tpc_drive.sv
module tpc_drive
  import tpc_pkg::*;
#(
  parameter logic RST_ADC_ON = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [CH_W-1:0] act_addr,
  input  logic            act_sgl,
  input  logic            act_pd0,
  input  logic            in_meas,
  input  logic            pen_armed,
  input  logic            ph_acq,
  input  logic            ph_conv,
  output logic            drv_xp,
  output logic            drv_xn,
  output logic            drv_yp,
  output logic            drv_yn,
  output logic            diode_bias_en,
  output logic            diode_hi_bias,
  output logic            bat_div_en,
  output logic            adc_pwr_en
);
  logic acq_now, conv_now, drive_window, yn_ground;
  drv_t drv_nx;

  assign acq_now      = in_meas & ph_acq;
  assign conv_now     = in_meas & ph_conv;
  assign drive_window = acq_now | (conv_now & ~act_sgl);
  assign yn_ground    = ~in_meas & pen_armed;

  always_comb begin
    drv_nx = '0;
    if (drive_window && is_touch_ch(act_addr)) drv_nx = touch_drivers(act_addr);
    drv_nx.yn = drv_nx.yn | yn_ground;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drv_xp        <= 1'b0;
      drv_xn        <= 1'b0;
      drv_yp        <= 1'b0;
      drv_yn        <= 1'b0;
      diode_bias_en <= 1'b0;
      diode_hi_bias <= 1'b0;
      bat_div_en    <= 1'b0;
      adc_pwr_en    <= RST_ADC_ON;
    end else begin
      drv_xp        <= drv_nx.xp;
      drv_xn        <= drv_nx.xn;
      drv_yp        <= drv_nx.yp;
      drv_yn        <= drv_nx.yn;
      diode_bias_en <= acq_now & is_diode_ch(act_addr);
      diode_hi_bias <= acq_now & (act_addr == CH_TEMP_HI);
      bat_div_en    <= acq_now & (act_addr == CH_BATT);
      adc_pwr_en    <= act_pd0 | in_meas;
    end
  end
endmodule

// File: rtl/tpc_pen.sv
module tpc_pen
  import tpc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [CH_W-1:0] act_addr,
  input  logic            in_meas,
  input  logic            pen_armed,
  input  logic            pen_touch_n,
  output logic            pen_irq_n,
  output logic            xp_pullup_en
);
  logic pen_nx;

  always_comb begin
    if (in_meas)        pen_nx = ~is_touch_ch(act_addr);
    else if (pen_armed) pen_nx = pen_touch_n;
    else                pen_nx = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pen_irq_n    <= 1'b1;
      xp_pullup_en <= 1'b0;
    end else begin
      pen_irq_n    <= pen_nx;
      xp_pullup_en <= ~in_meas & pen_armed;
    end
  end
endmodule

// File: rtl/touch_pwr_ctl.sv
module touch_pwr_ctl
  import tpc_pkg::*;
#(
  parameter logic RST_ADC_ON = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_load,
  input  logic [CH_W-1:0] cfg_addr,
  input  logic            cfg_sgl,
  input  logic [1:0]      cfg_pd,
  input  logic            ph_acq,
  input  logic            ph_conv,
  input  logic            busy_rise,
  input  logic            conv_end,
  input  logic            pen_touch_n,
  output logic            drv_xp,
  output logic            drv_xn,
  output logic            drv_yp,
  output logic            drv_yn,
  output logic            diode_bias_en,
  output logic            diode_hi_bias,
  output logic            bat_div_en,
  output logic            ref_en,
  output logic            adc_pwr_en,
  output logic            xp_pullup_en,
  output logic            pen_irq_n
);
  logic [CH_W-1:0] act_addr;
  logic            act_sgl, act_pd0, in_meas, pen_armed;

  tpc_state #(.RST_ADC_ON(RST_ADC_ON)) u_state (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_addr(cfg_addr),
    .cfg_sgl(cfg_sgl), .cfg_pd(cfg_pd), .busy_rise(busy_rise), .conv_end(conv_end),
    .act_addr(act_addr), .act_sgl(act_sgl), .act_pd0(act_pd0), .in_meas(in_meas),
    .pen_armed(pen_armed), .ref_en(ref_en)
  );

  tpc_drive #(.RST_ADC_ON(RST_ADC_ON)) u_drive (
    .clk(clk), .rst_n(rst_n), .act_addr(act_addr), .act_sgl(act_sgl),
    .act_pd0(act_pd0), .in_meas(in_meas), .pen_armed(pen_armed),
    .ph_acq(ph_acq), .ph_conv(ph_conv),
    .drv_xp(drv_xp), .drv_xn(drv_xn), .drv_yp(drv_yp), .drv_yn(drv_yn),
    .diode_bias_en(diode_bias_en), .diode_hi_bias(diode_hi_bias),
    .bat_div_en(bat_div_en), .adc_pwr_en(adc_pwr_en)
  );

  tpc_pen u_pen (
    .clk(clk), .rst_n(rst_n), .act_addr(act_addr), .in_meas(in_meas),
    .pen_armed(pen_armed), .pen_touch_n(pen_touch_n),
    .pen_irq_n(pen_irq_n), .xp_pullup_en(xp_pullup_en)
  );
endmodule

// File: rtl/touch_pwr_ctl_chk.sv
module touch_pwr_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_load,
  input logic [1:0] cfg_pd,
  input logic       ph_acq,
  input logic       busy_rise,
  input logic       drv_xp,
  input logic       drv_yp,
  input logic       diode_bias_en,
  input logic       bat_div_en,
  input logic       ref_en,
  input logic       adc_pwr_en,
  input logic       xp_pullup_en
);
  AST_BIAS_IN_ACQ: assert property (@(posedge clk) disable iff (!rst_n)
    diode_bias_en |-> $past(ph_acq)); // R1
  AST_DIV_IN_ACQ: assert property (@(posedge clk) disable iff (!rst_n)
    bat_div_en |-> $past(ph_acq)); // R2
  AST_REF_AT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ref_en) |-> $past(busy_rise)); // R7
  AST_ADC_STAYS_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_load && cfg_pd[0]) |=> ##1 adc_pwr_en); // R6
  AST_NO_CROSS_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(drv_xp && drv_yp)); // R5
  AST_PULLUP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    xp_pullup_en |-> !drv_xp); // R9
endmodule

bind touch_pwr_ctl touch_pwr_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_pd(cfg_pd),
  .ph_acq(ph_acq), .busy_rise(busy_rise), .drv_xp(drv_xp), .drv_yp(drv_yp),
  .diode_bias_en(diode_bias_en), .bat_div_en(bat_div_en), .ref_en(ref_en),
  .adc_pwr_en(adc_pwr_en), .xp_pullup_en(xp_pullup_en)
);

// File: tb/touch_pwr_ctl_tb.sv
module touch_pwr_ctl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_load = 1'b0, cfg_sgl = 1'b1, ph_acq = 1'b0, ph_conv = 1'b0;
  logic busy_rise = 1'b0, conv_end = 1'b0, pen_touch_n = 1'b1;
  logic [2:0] cfg_addr = 3'b000;
  logic [1:0] cfg_pd = 2'b00;
  logic drv_xp, drv_xn, drv_yp, drv_yn, diode_bias_en, diode_hi_bias, bat_div_en;
  logic ref_en, adc_pwr_en, xp_pullup_en, pen_irq_n;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  touch_pwr_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_addr(cfg_addr),
    .cfg_sgl(cfg_sgl), .cfg_pd(cfg_pd), .ph_acq(ph_acq), .ph_conv(ph_conv),
    .busy_rise(busy_rise), .conv_end(conv_end), .pen_touch_n(pen_touch_n),
    .drv_xp(drv_xp), .drv_xn(drv_xn), .drv_yp(drv_yp), .drv_yn(drv_yn),
    .diode_bias_en(diode_bias_en), .diode_hi_bias(diode_hi_bias),
    .bat_div_en(bat_div_en), .ref_en(ref_en), .adc_pwr_en(adc_pwr_en),
    .xp_pullup_en(xp_pullup_en), .pen_irq_n(pen_irq_n)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // bench model of the panel plates: {xp,xn,yp,yn}
  function automatic logic [3:0] plates(input logic [2:0] a);
    if (a == 3'd1) return 4'b0011;
    if (a == 3'd5) return 4'b1100;
    if (a == 3'd3 || a == 3'd4) return 4'b0110;
    return 4'b0000;
  endfunction

  function automatic logic pos_ch(input logic [2:0] a);
    return plates(a) != 4'b0000;
  endfunction

  task automatic chk_plates(input string tag, input logic [3:0] e);
    chk({tag, " xp"}, drv_xp, e[3]);
    chk({tag, " xn"}, drv_xn, e[2]);
    chk({tag, " yp"}, drv_yp, e[1]);
    chk({tag, " yn"}, drv_yn, e[0]);
  endtask

  task automatic load_byte(input logic [2:0] a, input logic s, input logic [1:0] pd);
    cfg_addr = a; cfg_sgl = s; cfg_pd = pd; cfg_load = 1'b1;
    tick();
    cfg_load = 1'b0;
    tick();
  endtask

  task automatic end_conv();
    conv_end = 1'b1;
    tick();
    conv_end = 1'b0;
    tick();
  endtask

  // acquire three cycles, convert four, checking drivers/bias/divider
  task automatic run_phases(input logic [2:0] a, input logic s);
    ph_acq = 1'b1;
    for (int i = 0; i < 3; i++) begin
      tick();
      chk_plates("R3/R5 acquire", plates(a));
      chk("R1 bias acquire", diode_bias_en, (a == 3'd0 || a == 3'd7));
      chk("R1 high bias", diode_hi_bias, (a == 3'd7));
      chk("R2 divider acquire", bat_div_en, (a == 3'd2));
    end
    ph_acq = 1'b0; ph_conv = 1'b1; busy_rise = 1'b1;
    tick();
    busy_rise = 1'b0;
    for (int i = 0; i < 4; i++) begin
      chk_plates(s ? "R3 convert single" : "R4 convert diff", s ? 4'b0000 : plates(a));
      chk("R1 bias off in convert", diode_bias_en, 1'b0);
      chk("R2 divider off in convert", bat_div_en, 1'b0);
      tick();
    end
    ph_conv = 1'b0;
    end_conv();
  endtask

  task automatic t_reset();
    chk("R10 ref", ref_en, 1'b0);
    chk("R10 adc", adc_pwr_en, 1'b1);
    chk("R10 pen", pen_irq_n, 1'b1);
    chk("R10 pullup", xp_pullup_en, 1'b0);
    chk_plates("R10 drivers", 4'b0000);
  endtask

  task automatic t_channels();
    for (int m = 0; m < 2; m++) begin
      for (int a = 0; a < 8; a++) begin
        pen_touch_n = a[0];
        load_byte(3'(a), m[0], 2'b11);
        chk("R8 pen forced", pen_irq_n, !pos_ch(3'(a)));
        chk("R8 pullup off", xp_pullup_en, 1'b0);
        chk("R6 adc full power", adc_pwr_en, 1'b1);
        run_phases(3'(a), m[0]);
        chk("R6 adc stays on", adc_pwr_en, 1'b1);
        chk("R9 disarmed pen", pen_irq_n, 1'b1);
      end
    end
    pen_touch_n = 1'b1;
  endtask

  task automatic t_autopd();
    load_byte(3'd1, 1'b1, 2'b00);
    chk("R6 adc on in measurement", adc_pwr_en, 1'b1);
    run_phases(3'd1, 1'b1);
    chk("R6 adc off after end", adc_pwr_en, 1'b0);
    chk("R9 pullup armed", xp_pullup_en, 1'b1);
    chk("R9 y-minus ground", drv_yn, 1'b1);
    chk("R9 pen idle high", pen_irq_n, 1'b1);
    pen_touch_n = 1'b0;
    tick();
    chk("R9 pen follows touch", pen_irq_n, 1'b0);
    load_byte(3'd6, 1'b1, 2'b01);
    chk("R8 pen forced high aux", pen_irq_n, 1'b1);
    chk("R9 no ground in meas", drv_yn, 1'b0);
    run_phases(3'd6, 1'b1);
    chk("R9 pd0=1 pen stays high", pen_irq_n, 1'b1);
    chk("R9 pd0=1 no pullup", xp_pullup_en, 1'b0);
    chk("R9 pd0=1 no ground", drv_yn, 1'b0);
    chk("R6 pd0=1 adc on", adc_pwr_en, 1'b1);
    load_byte(3'd6, 1'b1, 2'b00);
    run_phases(3'd6, 1'b1);
    chk("R9 re-armed by pd0=0", pen_irq_n, 1'b0);
    pen_touch_n = 1'b1;
    tick();
    chk("R9 pen released", pen_irq_n, 1'b1);
  endtask

  task automatic t_ref();
    chk("R7 ref initially off", ref_en, 1'b0);
    load_byte(3'd6, 1'b1, 2'b10);
    chk("R7 load leaves ref", ref_en, 1'b0);
    busy_rise = 1'b1;
    tick();
    busy_rise = 1'b0;
    chk("R7 busy sets ref", ref_en, 1'b1);
    end_conv();
    load_byte(3'd6, 1'b1, 2'b00);
    chk("R7 load keeps ref on", ref_en, 1'b1);
    end_conv();
    chk("R7 end keeps ref on", ref_en, 1'b1);
    busy_rise = 1'b1;
    tick();
    busy_rise = 1'b0;
    chk("R7 busy clears ref", ref_en, 1'b0);
  endtask

  task automatic t_overlap();
    load_byte(3'd5, 1'b0, 2'b00);
    ph_acq = 1'b1; tick();
    ph_acq = 1'b0; ph_conv = 1'b1; tick();
    ph_conv = 1'b0;
    cfg_addr = 3'd1; cfg_sgl = 1'b0; cfg_pd = 2'b00;
    cfg_load = 1'b1; conv_end = 1'b1;
    tick();
    cfg_load = 1'b0; conv_end = 1'b0;
    pen_touch_n = 1'b1;
    tick();
    chk("R11 pen still forced", pen_irq_n, 1'b0);
    chk("R11 no pullup", xp_pullup_en, 1'b0);
    chk("R11 no ground", drv_yn, 1'b0);
    chk("R11 adc on", adc_pwr_en, 1'b1);
    run_phases(3'd1, 1'b0);
    chk("R11 armed after second end", xp_pullup_en, 1'b1);
  endtask

  initial begin
    tick(); tick();
    t_reset();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_channels();
    t_autopd();
    t_ref();
    t_overlap();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule